// File: doc/BRIEF.md
# Fully Associative Translation Buffer with Access Checking

This block holds recently used virtual-to-physical page mappings in a fully associative array of entries. A lookup presents a 32-bit virtual address, whether the access is a write, and whether the requester runs in user or kernel mode. Bits 31:12 form the virtual page number, which is compared against every valid tag at once. The result comes back combinationally in the same cycle as the request.

A matching entry passes through a permission check before its page number is used. If the access is allowed, the block reports a hit and drives the physical address: the stored physical page number joined with the untouched 12-bit offset. A denied access reports a fault with a cause code and drives no address. A lookup that matches nothing reports a miss. An external page walker can then load the mapping through the fill port. Fills overwrite entries in first-in first-out order. A flush input empties the whole array in one cycle.

Top module: `tlb_xlate`

## Requirements
- R1: After reset every entry is invalid, so any lookup reports a miss, and the replacement pointer starts at entry 0.
- R2: A request whose page number (vaddr bits 31:12) matches no valid entry raises `miss` in the same cycle, with `hit` and `prot_fault` low.
- R3: A permitted access to a matching entry raises `hit` in the same cycle, with `paddr` equal to the stored page number above vaddr bits 11:0.
- R4: Each fill writes the entry under the replacement pointer, and the fill takes effect at the next rising edge. The pointer then steps by one and wraps after the last of the 32 entries. As a result, the 33rd fill since reset or flush evicts the first entry that was filled.
- R5: A read of an entry whose read-permission bit is clear faults with cause 2'b01.
- R6: A write to an entry whose write-permission bit is clear faults with cause 2'b01.
- R7: A user-mode access to an entry whose user bit is clear faults with cause 2'b10. This check outranks the access-permission and dirty checks. Kernel-mode accesses ignore the user bit.
- R8: A write that passes the other checks but hits an entry whose dirty bit is clear faults with cause 2'b11.
- R9: A flush invalidates every entry at the next edge and resets the pointer to entry 0. When a flush and a fill arrive in the same cycle, the flush wins and the fill is dropped.
- R10: While `req_valid` is low, `hit`, `miss` and `prot_fault` are low, `paddr` is zero and `fault_cause` is 2'b00.
- R11: Whenever `hit` is low, `paddr` is zero. Whenever `prot_fault` is low, `fault_cause` is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 = write access, 0 = read |
| req_user | input | 1 | 1 = user mode, 0 = kernel |
| fill_en | input | 1 | Write a new entry at the replacement pointer |
| fill_vpn | input | 20 | Virtual page number of the new entry |
| fill_ppn | input | 20 | Physical page number of the new entry |
| fill_rd | input | 1 | Read permission of the new entry |
| fill_wr | input | 1 | Write permission of the new entry |
| fill_dirty | input | 1 | Dirty bit of the new entry |
| fill_user | input | 1 | User-accessible bit of the new entry |
| flush | input | 1 | Invalidate all entries, reset pointer |
| hit | output | 1 | Permitted translation |
| miss | output | 1 | No valid entry matched |
| paddr | output | 32 | Physical address on hit, else zero |
| prot_fault | output | 1 | Matching entry denied the access |
| fault_cause | output | 2 | 01 access, 10 privilege, 11 dirty update, 00 none |

## Verification
The assertions take for granted that no two valid entries hold the same page number. The match vector can therefore carry at most one set bit, and the output multiplexer is an OR of the masked entries. The stimulus honours this by giving each fill a page number that is not already resident. Where a number is reused, it is reused only after a flush or after its old entry has been evicted. Inputs change only on falling edges, so each combinational lookup result is stable while it is sampled, and each fill is captured at exactly one rising edge.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int VA_W      = 32;
    localparam int PA_W      = 32;
    localparam int OFFSET_W  = 12;
    localparam int VPN_W     = VA_W - OFFSET_W;
    localparam int PPN_W     = PA_W - OFFSET_W;

    typedef struct packed {
        logic             valid;
        logic             rd;
        logic             wr;
        logic             dirty;
        logic             usr;
        logic [VPN_W-1:0] vpn;
        logic [PPN_W-1:0] ppn;
    } tlb_entry_t;

    typedef enum logic [1:0] {
        FC_NONE   = 2'b00,
        FC_ACCESS = 2'b01,
        FC_PRIV   = 2'b10,
        FC_DIRTY  = 2'b11
    } fault_cause_t;

    function automatic logic [PA_W-1:0] join_pa(input logic [PPN_W-1:0] ppn,
                                                input logic [OFFSET_W-1:0] off);
        return {ppn, off};
    endfunction
endpackage

// File: rtl/tlb_fifo_ptr.sv
module tlb_fifo_ptr #(
    parameter int ENTRIES = 32,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             advance,
    output logic [IDX_W-1:0] ptr
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            ptr <= '0;
        end else if (advance) begin
            ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
        end
    end

    assert_flush_ptr_zero_R9: assert property (@(posedge clk) disable iff (rst)
        flush |=> (ptr == '0));
    assert_ptr_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (!advance && !flush) |=> $stable(ptr));
endmodule

// File: rtl/tlb_entry_array.sv
module tlb_entry_array
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 32,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               flush,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  tlb_entry_t         wr_entry,
    input  logic [VPN_W-1:0]   look_vpn,
    output logic               any_match,
    output tlb_entry_t         sel_entry
);
    tlb_entry_t         store_q [ENTRIES];
    logic [ENTRIES-1:0] match_vec;
    logic [ENTRIES-1:0] valid_vec;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst || flush) begin
                store_q[g].valid <= 1'b0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                store_q[g] <= wr_entry;
            end
        end
        assign valid_vec[g] = store_q[g].valid;
        assign match_vec[g] = store_q[g].valid && (store_q[g].vpn == look_vpn);
    end

    always_comb begin
        sel_entry = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match_vec[i]) begin
                sel_entry = tlb_entry_t'(sel_entry | store_q[i]);
            end
        end
    end

    assign any_match = |match_vec;

    assert_unique_match_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(match_vec));
    assert_flush_empties_R9: assert property (@(posedge clk) disable iff (rst)
        flush |=> (valid_vec == '0));
endmodule

// File: rtl/tlb_perm_check.sv
module tlb_perm_check
    import tlb_pkg::*;
(
    input  tlb_entry_t   ent,
    input  logic         is_write,
    input  logic         is_user,
    output logic         deny,
    output fault_cause_t cause
);
    always_comb begin
        cause = FC_NONE;
        if (is_user && !ent.usr) begin
            cause = FC_PRIV;
        end else if (is_write ? !ent.wr : !ent.rd) begin
            cause = FC_ACCESS;
        end else if (is_write && !ent.dirty) begin
            cause = FC_DIRTY;
        end
    end

    assign deny = (cause != FC_NONE);

    always_comb begin
        if (cause == FC_DIRTY) begin
            assert_dirty_on_write_R8: assert (is_write);
        end
        if (cause == FC_PRIV) begin
            assert_priv_only_user_R7: assert (is_user);
        end
    end
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 32,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [VA_W-1:0]  req_vaddr,
    input  logic             req_write,
    input  logic             req_user,
    input  logic             fill_en,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PPN_W-1:0] fill_ppn,
    input  logic             fill_rd,
    input  logic             fill_wr,
    input  logic             fill_dirty,
    input  logic             fill_user,
    input  logic             flush,
    output logic             hit,
    output logic             miss,
    output logic [PA_W-1:0]  paddr,
    output logic             prot_fault,
    output logic [1:0]       fault_cause
);
    logic [IDX_W-1:0] victim;
    logic             any_match;
    tlb_entry_t       sel_entry;
    tlb_entry_t       new_entry;
    logic             deny;
    fault_cause_t     cause;
    logic             found;

    always_comb begin
        new_entry.valid = 1'b1;
        new_entry.rd    = fill_rd;
        new_entry.wr    = fill_wr;
        new_entry.dirty = fill_dirty;
        new_entry.usr   = fill_user;
        new_entry.vpn   = fill_vpn;
        new_entry.ppn   = fill_ppn;
    end

    tlb_fifo_ptr #(.ENTRIES(ENTRIES)) u_ptr (
        .clk     (clk),
        .rst     (rst),
        .flush   (flush),
        .advance (fill_en),
        .ptr     (victim)
    );

    tlb_entry_array #(.ENTRIES(ENTRIES)) u_array (
        .clk       (clk),
        .rst       (rst),
        .flush     (flush),
        .wr_en     (fill_en),
        .wr_idx    (victim),
        .wr_entry  (new_entry),
        .look_vpn  (req_vaddr[VA_W-1:OFFSET_W]),
        .any_match (any_match),
        .sel_entry (sel_entry)
    );

    tlb_perm_check u_perm (
        .ent      (sel_entry),
        .is_write (req_write),
        .is_user  (req_user),
        .deny     (deny),
        .cause    (cause)
    );

    assign found       = req_valid && any_match;
    assign hit         = found && !deny;
    assign miss        = req_valid && !any_match;
    assign prot_fault  = found && deny;
    assign fault_cause = prot_fault ? cause : FC_NONE;
    assign paddr       = hit ? join_pa(sel_entry.ppn, req_vaddr[OFFSET_W-1:0]) : '0;

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        !req_valid |-> (!hit && !miss && !prot_fault));
    assert_fault_no_addr_R11: assert property (@(posedge clk) disable iff (rst)
        prot_fault |-> (paddr == '0 && !hit));
    assert_hit_miss_excl_R2: assert property (@(posedge clk) disable iff (rst)
        !(hit && miss) && !(miss && prot_fault));
endmodule

// File: tb/test_tlb_xlate.sv
`timescale 1ns/1ps
module test_tlb_xlate;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_write, req_user;
    logic [31:0] req_vaddr;
    logic        fill_en, fill_rd, fill_wr, fill_dirty, fill_user, flush;
    logic [19:0] fill_vpn, fill_ppn;
    logic        hit, miss, prot_fault;
    logic [31:0] paddr;
    logic [1:0]  fault_cause;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    tlb_xlate i_tlb_xlate (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .req_write(req_write), .req_user(req_user), .fill_en(fill_en),
        .fill_vpn(fill_vpn), .fill_ppn(fill_ppn), .fill_rd(fill_rd),
        .fill_wr(fill_wr), .fill_dirty(fill_dirty), .fill_user(fill_user),
        .flush(flush), .hit(hit), .miss(miss), .paddr(paddr),
        .prot_fault(prot_fault), .fault_cause(fault_cause)
    );

    typedef struct packed {
        logic [31:0] va;
        logic        wr;
        logic        usr;
        logic        e_hit;
        logic        e_miss;
        logic        e_flt;
        logic [1:0]  e_cause;
        logic [31:0] e_pa;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VT [NV] = '{
        '{32'h00010ABC, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 2'b00, 32'hABCDEABC}, // R3
        '{32'h00010FFF, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 2'b00, 32'hABCDEFFF}, // R3
        '{32'h00020001, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 2'b00, 32'h12345001}, // R3
        '{32'h00020001, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 2'b01, 32'h0},        // R6
        '{32'h00030123, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 2'b11, 32'h0},        // R8
        '{32'h00030123, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 2'b00, 32'h55555123}, // R8 read ok
        '{32'h00040010, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 2'b10, 32'h0},        // R7
        '{32'h00040010, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 2'b00, 32'h0F0F0010}, // R7 kernel
        '{32'h00040010, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 2'b00, 32'h0F0F0010}, // R7 kernel
        '{32'h00050000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'b01, 32'h0},        // R5
        '{32'h00050000, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 2'b00, 32'h77777000}, // R5 write ok
        '{32'h00060000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'b00, 32'h0},        // R2
        '{32'h00070000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 2'b10, 32'h0},        // R7 priority
        '{32'h00070000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 2'b01, 32'h0}         // R6 priority
    };

    task automatic check(input string req, input logic [39:0] got, input logic [39:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic fill(input logic [19:0] vpn, input logic [19:0] ppn,
                        input logic r, input logic w, input logic d, input logic u);
        @(negedge clk);
        fill_en = 1'b1; fill_vpn = vpn; fill_ppn = ppn;
        fill_rd = r; fill_wr = w; fill_dirty = d; fill_user = u;
        @(negedge clk);
        fill_en = 1'b0;
    endtask

    task automatic look(input logic [31:0] va, input logic w, input logic u);
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; req_write = w; req_user = u;
        #1;
    endtask

    function automatic logic [39:0] pack_out();
        return {3'b0, hit, miss, prot_fault, fault_cause, paddr};
    endfunction

    function automatic logic [39:0] pack_exp(input logic h, input logic m, input logic f,
                                             input logic [1:0] c, input logic [31:0] pa);
        return {3'b0, h, m, f, c, pa};
    endfunction

    initial begin
        #1000000;
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; req_valid = 1'b0; req_vaddr = '0; req_write = 1'b0; req_user = 1'b0;
        fill_en = 1'b0; fill_vpn = '0; fill_ppn = '0; fill_rd = 1'b0; fill_wr = 1'b0;
        fill_dirty = 1'b0; fill_user = 1'b0; flush = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: empty after reset
        look(32'h00010ABC, 1'b0, 1'b0);
        check("R1 reset miss", pack_out(), pack_exp(1'b0, 1'b1, 1'b0, 2'b00, 32'h0));
        req_valid = 1'b0;

        fill(20'h00010, 20'hABCDE, 1, 1, 1, 1);
        fill(20'h00020, 20'h12345, 1, 0, 0, 1);
        fill(20'h00030, 20'h55555, 1, 1, 0, 1);
        fill(20'h00040, 20'h0F0F0, 1, 1, 1, 0);
        fill(20'h00050, 20'h77777, 0, 1, 1, 1);
        fill(20'h00070, 20'h11111, 1, 0, 0, 0);

        for (int i = 0; i < NV; i++) begin
            look(VT[i].va, VT[i].wr, VT[i].usr);
            check($sformatf("R2/R3/R5-R8/R11 vector %0d", i), pack_out(),
                  pack_exp(VT[i].e_hit, VT[i].e_miss, VT[i].e_flt, VT[i].e_cause, VT[i].e_pa));
        end

        // R10: idle request gives quiet outputs even with a matching address
        @(negedge clk);
        req_valid = 1'b0; req_vaddr = 32'h00010ABC;
        #1;
        check("R10 idle", pack_out(), pack_exp(1'b0, 1'b0, 1'b0, 2'b00, 32'h0));

        // R4: fill up to 32 entries; first entry survives
        for (int i = 0; i < 26; i++) fill(20'h00100 + 20'(i), 20'h00200 + 20'(i), 1, 1, 1, 1);
        look(32'h00010000, 1'b0, 1'b1);
        check("R4 full, first still resident", pack_out(),
              pack_exp(1'b1, 1'b0, 1'b0, 2'b00, 32'hABCDE000));
        req_valid = 1'b0;
        fill(20'h00200, 20'h00AAA, 1, 1, 1, 1);
        look(32'h00010000, 1'b0, 1'b1);
        check("R4 33rd fill evicts first", pack_out(), pack_exp(1'b0, 1'b1, 1'b0, 2'b00, 32'h0));
        look(32'h00020004, 1'b0, 1'b1);
        check("R4 second entry kept", pack_out(), pack_exp(1'b1, 1'b0, 1'b0, 2'b00, 32'h12345004));
        look(32'h00200008, 1'b0, 1'b1);
        check("R4 new entry hits", pack_out(), pack_exp(1'b1, 1'b0, 1'b0, 2'b00, 32'h00AAA008));
        req_valid = 1'b0;

        // R9: flush together with a fill; flush wins
        @(negedge clk);
        flush = 1'b1; fill_en = 1'b1; fill_vpn = 20'h00300; fill_ppn = 20'h00333;
        fill_rd = 1; fill_wr = 1; fill_dirty = 1; fill_user = 1;
        @(negedge clk);
        flush = 1'b0; fill_en = 1'b0;
        look(32'h00300000, 1'b0, 1'b0);
        check("R9 fill dropped on flush", pack_out(), pack_exp(1'b0, 1'b1, 1'b0, 2'b00, 32'h0));
        look(32'h00020000, 1'b0, 1'b0);
        check("R9 entries invalid", pack_out(), pack_exp(1'b0, 1'b1, 1'b0, 2'b00, 32'h0));
        req_valid = 1'b0;

        // R9: pointer restarted at 0 (pointer was at 1 before flush)
        for (int i = 0; i < 32; i++) fill(20'h00500 + 20'(i), 20'h00600 + 20'(i), 1, 1, 1, 1);
        look(32'h0051F010, 1'b0, 1'b1);
        check("R9 refill last hits", pack_out(), pack_exp(1'b1, 1'b0, 1'b0, 2'b00, 32'h0061F010));
        req_valid = 1'b0;
        fill(20'h00700, 20'h00777, 1, 1, 1, 1);
        look(32'h00500000, 1'b0, 1'b1);
        check("R9 pointer reset, first evicted", pack_out(),
              pack_exp(1'b0, 1'b1, 1'b0, 2'b00, 32'h0));
        look(32'h00501000, 1'b0, 1'b1);
        check("R9 second kept", pack_out(), pack_exp(1'b1, 1'b0, 1'b0, 2'b00, 32'h00601000));
        req_valid = 1'b0;

        // R1: reset again empties array
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        look(32'h00501000, 1'b0, 1'b1);
        check("R1 reset empties", pack_out(), pack_exp(1'b0, 1'b1, 1'b0, 2'b00, 32'h0));
        req_valid = 1'b0;

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule